// File: doc/BRIEF.md
# Quadrature Switched-Cell Drive Generator

This block forms the drive for an array of switched power cells that is shared by the in-phase and quadrature paths of a digital transmitter. A free-running clock at twice the carrier rate is divided by two to make four quadrature carrier phases. One sample of each signed baseband path is taken on every fourth rising edge of that clock, so the sample rate is half the carrier rate. Each sample becomes a sign and a saturated magnitude. The upper magnitude bits are decoded into a run of unary cell enables. The lower bits enable binary-weighted cells directly.

Every cell sees both paths. For each path, the sign picks which carrier phase the cell uses: in-phase uses 0° or 180°, quadrature uses 90° or 270°. That phase is ANDed with the cell's enable for the path. The two gated signals are then ORed at the cell input, so both paths drive one array and there is no second array.

Top module: `iqpa_driver`

## Requirements
- R1: A negative sample gives sign 1 and magnitude equal to its absolute value. Zero and positive samples give sign 0 and magnitude equal to the sample.
- R2: The most negative input (-2048 at the default 12-bit width) saturates to the largest magnitude, 2047, with sign 1. It does not wrap.
- R3: `lo_ph[0]` is the 0° phase and toggles on every rising edge of `clk2x`. `lo_ph[1]` is the 90° phase and takes the value of the 0° phase on each falling edge. `lo_ph[2]` and `lo_ph[3]` are the complements of bits 0 and 1 (180° and 270°).
- R4: The upper 6 magnitude bits form a code k. Unary enables 0 to k-1 are set and all others are clear, so code 0 sets none and code 63 sets all 63.
- R5: Binary cell b (b = 0 to 4) is enabled by magnitude bit b of a path.
- R6: Samples are taken once per four rising edges of `clk2x`: on the first edge after reset release, and then on every edge at which the 0° phase rises. All enables and signs hold between captures. `smp_clk` is high for the two `clk2x` cycles that start at a capture edge.
- R7: An in-phase sign of 0 selects the 0° phase and a sign of 1 selects 180°. A quadrature sign of 0 selects 90° and a sign of 1 selects 270°.
- R8: Each cell output is the OR of the in-phase selected phase ANDed with that cell's in-phase enable and the quadrature selected phase ANDed with its quadrature enable.
- R9: The synchronous active-high reset clears all enables and signs and holds all cell outputs low. While reset is held, `lo_ph` is 4'b1100. The 0° phase is the first phase to rise after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x | input | 1 | Clock at twice the carrier frequency |
| rst | input | 1 | Synchronous reset, active high |
| sample_i | input | 12 | Signed in-phase sample, two's complement |
| sample_q | input | 12 | Signed quadrature sample, two's complement |
| lo_ph | output | 4 | Carrier phases: bit 0 = 0°, bit 1 = 90°, bit 2 = 180°, bit 3 = 270° |
| smp_clk | output | 1 | Sample clock at half the carrier rate |
| unary_drv | output | 63 | Drive of the unary cells |
| binary_drv | output | 5 | Drive of the binary-weighted cells |

## Verification
The in-phase and quadrature paths can both claim the same cell while their selected phases are high at once, and the OR merge must then give one clean pulse and no cancellation. The bench provokes this with samples whose paths have equal or different signs and overlapping unary codes, including both full-scale extremes. It checks every cell at two points in each half carrier period, so each of the four phase combinations is seen against both enables. The captures also fall on the same edge as a 0° phase transition, and each new sample is judged against the phase value that holds just after that edge.

// File: rtl/iqpa_pkg.sv
`timescale 1ns/1ps
package iqpa_pkg;

    localparam int DEF_MAG_W = 11;
    localparam int DEF_BIN_W = 5;

    typedef struct packed {
        logic p270;
        logic p180;
        logic p90;
        logic p0;
    } lo_quad_t;

    typedef enum logic [1:0] {
        CAP_SLOT = 2'd0,
        SLOT_1   = 2'd1,
        SLOT_2   = 2'd2,
        SLOT_3   = 2'd3
    } slot_e;

    // Carrier phase used by one path of a cell, chosen by that path's sign
    function automatic logic pick_phase(input lo_quad_t lo, input logic quad, input logic neg);
        logic r;
        if (quad) r = neg ? lo.p270 : lo.p90;
        else      r = neg ? lo.p180 : lo.p0;
        return r;
    endfunction

endpackage

// File: rtl/iqpa_lo_gen.sv
`timescale 1ns/1ps
module iqpa_lo_gen
    import iqpa_pkg::*;
(
    input  logic     clk2x,
    input  logic     rst,
    output lo_quad_t lo,
    output logic     cap,
    output logic     smp_clk
);
    slot_e slot;
    logic  ph_q;

    always_ff @(posedge clk2x) begin
        if (rst) slot <= CAP_SLOT;
        else     slot <= slot_e'(slot + 2'd1);
    end

    // Quadrature flop trails the in-phase divider by half a clk2x period
    always_ff @(negedge clk2x) begin
        if (rst) ph_q <= 1'b0;
        else     ph_q <= slot[0];
    end

    always_comb begin
        lo.p0   = slot[0];
        lo.p180 = ~slot[0];
        lo.p90  = ph_q;
        lo.p270 = ~ph_q;
    end

    assign cap     = (slot == CAP_SLOT);
    assign smp_clk = slot[0] ^ slot[1];
endmodule

// File: rtl/iqpa_path.sv
`timescale 1ns/1ps
module iqpa_path #(
    parameter int MAG_W = 11,
    parameter int BIN_W = 5,
    localparam int IN_W  = MAG_W + 1,
    localparam int THR_W = MAG_W - BIN_W,
    localparam int N_UN  = (1 << THR_W) - 1
) (
    input  logic                   clk2x,
    input  logic                   rst,
    input  logic                   cap,
    input  logic signed [IN_W-1:0] sample,
    output logic                   sgn,
    output logic [N_UN-1:0]        en_un,
    output logic [BIN_W-1:0]       en_bin
);
    logic            neg;
    logic [IN_W-1:0] absval;
    logic [MAG_W-1:0] mag;
    logic [THR_W-1:0] code;
    logic [N_UN-1:0]  thermo;

    always_comb begin
        neg    = sample[IN_W-1];
        absval = neg ? (~sample + 1'b1) : sample;
        // Only the most negative code leaves the top bit set: clamp it
        mag    = absval[IN_W-1] ? {MAG_W{1'b1}} : absval[MAG_W-1:0];
        code   = mag[MAG_W-1:BIN_W];
    end

    for (genvar j = 0; j < N_UN; j++) begin : g_thermo
        assign thermo[j] = (code > THR_W'(j));
    end

    always_ff @(posedge clk2x) begin
        if (rst) begin
            sgn    <= 1'b0;
            en_un  <= '0;
            en_bin <= '0;
        end else if (cap) begin
            sgn    <= neg;
            en_un  <= thermo;
            en_bin <= mag[BIN_W-1:0];
        end
    end
endmodule

// File: rtl/iqpa_cell.sv
`timescale 1ns/1ps
module iqpa_cell
    import iqpa_pkg::*;
(
    input  lo_quad_t lo,
    input  logic     sgn_i,
    input  logic     sgn_q,
    input  logic     en_i,
    input  logic     en_q,
    output logic     drv
);
    logic g_i, g_q;
    assign g_i = pick_phase(lo, 1'b0, sgn_i) & en_i;
    assign g_q = pick_phase(lo, 1'b1, sgn_q) & en_q;
    assign drv = g_i | g_q;
endmodule

// File: rtl/iqpa_driver.sv
`timescale 1ns/1ps
module iqpa_driver
    import iqpa_pkg::*;
#(
    parameter int MAG_W = DEF_MAG_W,
    parameter int BIN_W = DEF_BIN_W,
    localparam int IN_W  = MAG_W + 1,
    localparam int THR_W = MAG_W - BIN_W,
    localparam int N_UN  = (1 << THR_W) - 1
) (
    input  logic                   clk2x,
    input  logic                   rst,
    input  logic signed [IN_W-1:0] sample_i,
    input  logic signed [IN_W-1:0] sample_q,
    output logic [3:0]             lo_ph,
    output logic                   smp_clk,
    output logic [N_UN-1:0]        unary_drv,
    output logic [BIN_W-1:0]       binary_drv
);
    lo_quad_t         lo;
    logic             cap;
    logic             sgn_i, sgn_q;
    logic [N_UN-1:0]  en_i, en_q;
    logic [BIN_W-1:0] bin_i, bin_q;

    iqpa_lo_gen u_lo (
        .clk2x  (clk2x),
        .rst    (rst),
        .lo     (lo),
        .cap    (cap),
        .smp_clk(smp_clk)
    );

    iqpa_path #(.MAG_W(MAG_W), .BIN_W(BIN_W)) u_path_i (
        .clk2x(clk2x), .rst(rst), .cap(cap), .sample(sample_i),
        .sgn(sgn_i), .en_un(en_i), .en_bin(bin_i)
    );

    iqpa_path #(.MAG_W(MAG_W), .BIN_W(BIN_W)) u_path_q (
        .clk2x(clk2x), .rst(rst), .cap(cap), .sample(sample_q),
        .sgn(sgn_q), .en_un(en_q), .en_bin(bin_q)
    );

    for (genvar k = 0; k < N_UN; k++) begin : g_unary
        iqpa_cell u_cell (
            .lo(lo), .sgn_i(sgn_i), .sgn_q(sgn_q),
            .en_i(en_i[k]), .en_q(en_q[k]), .drv(unary_drv[k])
        );
    end

    for (genvar b = 0; b < BIN_W; b++) begin : g_binary
        iqpa_cell u_cell (
            .lo(lo), .sgn_i(sgn_i), .sgn_q(sgn_q),
            .en_i(bin_i[b]), .en_q(bin_q[b]), .drv(binary_drv[b])
        );
    end

    assign lo_ph = {lo.p270, lo.p180, lo.p90, lo.p0};
endmodule

// File: rtl/iqpa_driver_chk.sv
`timescale 1ns/1ps
module iqpa_driver_chk #(
    parameter int N_UN = 63,
    parameter int BIN_W = 5
) (
    input logic             clk2x,
    input logic             rst,
    input logic [3:0]       lo_ph,
    input logic             smp_clk,
    input logic [N_UN-1:0]  en_i,
    input logic [N_UN-1:0]  en_q,
    input logic [N_UN-1:0]  unary_drv,
    input logic [BIN_W-1:0] binary_drv
);
    AST_LO_TOGGLE: assert property (@(posedge clk2x) disable iff (rst)
        !$past(rst) |-> (lo_ph[0] != $past(lo_ph[0]))); // R3

    AST_LO_QUAD: assert property (@(posedge clk2x) disable iff (rst)
        lo_ph[1] == lo_ph[0]); // R3

    AST_THERMO_SHAPE: assert property (@(posedge clk2x) disable iff (rst)
        (((en_i >> 1) & ~en_i) == '0) && (((en_q >> 1) & ~en_q) == '0)); // R4

    AST_HOLD_BETWEEN: assert property (@(posedge clk2x) disable iff (rst)
        !$rose(smp_clk) |-> ($stable(en_i) && $stable(en_q))); // R6

    AST_SMP_WIDTH: assert property (@(posedge clk2x) disable iff (rst)
        $rose(smp_clk) |=> smp_clk); // R6

    AST_RESET_QUIET: assert property (@(posedge clk2x) disable iff (rst)
        $fell(rst) |-> (unary_drv == '0 && binary_drv == '0 && lo_ph == 4'b1100)); // R9
endmodule

bind iqpa_driver iqpa_driver_chk #(.N_UN(N_UN), .BIN_W(BIN_W)) u_chk (
    .clk2x(clk2x), .rst(rst), .lo_ph(lo_ph), .smp_clk(smp_clk),
    .en_i(en_i), .en_q(en_q), .unary_drv(unary_drv), .binary_drv(binary_drv)
);

// File: tb/tb_iqpa_driver.sv
`timescale 1ns/1ps
module tb_iqpa_driver;
    localparam int MAG_W = 11;
    localparam int BIN_W = 5;
    localparam int IN_W  = MAG_W + 1;
    localparam int THR_W = MAG_W - BIN_W;
    localparam int N_UN  = (1 << THR_W) - 1;

    logic                   clk2x = 1'b0;
    logic                   rst   = 1'b1;
    logic signed [IN_W-1:0] sample_i = '0;
    logic signed [IN_W-1:0] sample_q = '0;
    logic [3:0]             lo_ph;
    logic                   smp_clk;
    logic [N_UN-1:0]        unary_drv;
    logic [BIN_W-1:0]       binary_drv;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk2x = ~clk2x;

    iqpa_driver dut (
        .clk2x(clk2x), .rst(rst), .sample_i(sample_i), .sample_q(sample_q),
        .lo_ph(lo_ph), .smp_clk(smp_clk), .unary_drv(unary_drv), .binary_drv(binary_drv)
    );

    function automatic logic ref_sign(input logic signed [IN_W-1:0] x);
        return x < 0;
    endfunction

    function automatic int ref_mag(input logic signed [IN_W-1:0] x);
        int v = int'(x);
        if (v < 0) v = -v;
        if (v > (1 << MAG_W) - 1) v = (1 << MAG_W) - 1;
        return v;
    endfunction

    function automatic logic [N_UN-1:0] ref_unary(input logic di, input logic dq,
                                                  input int mi, input int mq);
        logic [N_UN-1:0] r;
        int ki = mi >> BIN_W;
        int kq = mq >> BIN_W;
        for (int j = 0; j < N_UN; j++)
            r[j] = (di && (j < ki)) || (dq && (j < kq));
        return r;
    endfunction

    function automatic logic [BIN_W-1:0] ref_binary(input logic di, input logic dq,
                                                    input int mi, input int mq);
        logic [BIN_W-1:0] r;
        for (int b = 0; b < BIN_W; b++)
            r[b] = (di && mi[b]) || (dq && mq[b]);
        return r;
    endfunction

    task automatic chk_vec(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // One sample: drive it, then check all outputs at two points in each of four clk2x cycles
    task automatic run_sample(input logic signed [IN_W-1:0] xi, input logic signed [IN_W-1:0] xq);
        logic si, sq, p0, p90, di, dq;
        int   mi, mq;
        sample_i = xi;
        sample_q = xq;
        si = ref_sign(xi);  sq = ref_sign(xq);
        mi = ref_mag(xi);   mq = ref_mag(xq);
        for (int c = 0; c < 4; c++) begin
            @(posedge clk2x);
            for (int h = 0; h < 2; h++) begin
                #2;
                p0  = (c % 2 == 0);
                p90 = (h == 0) ? !p0 : p0;
                di  = si ? !p0 : p0;      // R7 in-phase 0/180
                dq  = sq ? !p90 : p90;    // R7 quadrature 90/270
                chk_vec("R3 lo_ph", 128'(lo_ph), 128'({!p90, !p0, p90, p0}));
                chk_vec("R6 smp_clk", 128'(smp_clk), 128'(c < 2));
                chk_vec("R1 R2 R4 R8 unary", 128'(unary_drv), 128'(ref_unary(di, dq, mi, mq)));
                chk_vec("R1 R5 R8 binary", 128'(binary_drv), 128'(ref_binary(di, dq, mi, mq)));
                if (h == 0) #2;
            end
        end
    endtask

    initial begin
        logic signed [IN_W-1:0] dir_i [12];
        logic signed [IN_W-1:0] dir_q [12];
        void'($urandom(32'd20240611));
        dir_i = '{12'sd0, 12'sd2047, 12'sd0, -12'sd2048, -12'sd1, 12'sd32,
                  12'sd31, -12'sd33, 12'sd2016, -12'sd2048, 12'sd1000, -12'sd1000};
        dir_q = '{12'sd0, 12'sd0, -12'sd2048, 12'sd2047, 12'sd1, -12'sd31,
                  -12'sd32, -12'sd33, -12'sd2047, -12'sd2048, 12'sd1000, 12'sd999};
        repeat (3) @(posedge clk2x);
        #2;
        // R9: outputs quiet and phases parked while reset is held
        chk_vec("R9 reset unary", 128'(unary_drv), 128'(0));
        chk_vec("R9 reset binary", 128'(binary_drv), 128'(0));
        chk_vec("R9 reset lo_ph", 128'(lo_ph), 128'(4'b1100));
        chk_vec("R9 reset smp_clk", 128'(smp_clk), 128'(0));
        #4;
        rst = 1'b0;
        for (int v = 0; v < 12; v++) run_sample(dir_i[v], dir_q[v]);
        for (int v = 0; v < 60; v++) begin
            logic signed [IN_W-1:0] ri, rq;
            ri = IN_W'($urandom);
            rq = IN_W'($urandom);
            if ($urandom_range(0, 7) == 0) ri = -12'sd2048;  // R2 extreme mixed in
            run_sample(ri, rq);
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end
endmodule